// File: doc/BRIEF.md
# Floppy Controller Host Command and Result Sequencer

This block is the host-facing front end of a floppy disk controller. The host writes a command byte and its parameter bytes into a byte-wide data port, and reads the controller's main status byte to learn when the next byte may move and in which direction. The block decodes the command and handles configuration, interrupt-status polling and unknown commands by itself. For seek and recalibrate it starts a per-drive positioning job and tracks it. For data transfers it starts an external execution stub and, when that finishes, packs the stub's 24-bit completion word into seven result bytes for the host to read back.

Both directions of the data port are valid/ready streams. A host byte is written on a cycle where `wr_valid` and `wr_ready` are both high. While `wr_ready` is low the host must hold the byte and keep `wr_valid` up. `wr_ready` is high only when the status flags show request-for-master set and data-direction clear. A byte is read on a cycle where `rd_valid` and `rd_ready` are both high. `rd_data` holds steady while `rd_valid` waits for `rd_ready`, and `rd_valid` is high only when request-for-master and data-direction are both set. Interrupt and DMA request outputs are plain pins, each with its own mask input.

Top module: `fdc_host_seq`

## Requirements
- R1: After reset `msr` is 0x80, `irq`, `drq` and `rd_valid` are low, and `wr_ready` is high.
- R2: `msr` bits 7..4 are request-for-master, data-direction (1 = to host), non-DMA execution and controller-busy. A host write is taken only when bit 7 = 1 and bit 6 = 0. A byte offered while `wr_ready` is low is ignored.
- R3: The command code is the low 5 bits of the first byte. Bits 7 and 5 are option flags, passed unchanged on `exec_cmd`. While parameter bytes are being collected, `msr` reads 0x90.
- R4: Specify (code 0x03, two parameters) sets `step_rate` from parameter 0 bits 7:4 and `nondma` from parameter 1 bit 0. It produces no result bytes and leaves `msr` at 0x80.
- R5: Any code not listed in R4, R6, R9 or R10 gives one result byte 0x80, with `msr` 0xD0 while that byte waits.
- R6: Read (0x06, 0x0C), write (0x05, 0x09) and scan (0x11, 0x19, 0x1D) take eight parameters: unit, C, H, R, N, EOT, GPL, DTL. After the last one, `exec_start` pulses for exactly one cycle, `exec_unit` shows the unit byte, and `msr` reads 0xF0 for read or 0xB0 for write and scan.
- R7: A `tc` or `exec_done` pulse during execution moves to the result phase (`msr` 0xD0). The seven bytes are: {status[7:3], unit[2:0]}, status[15:8], status[23:16], then C, H, R, N.
- R8: After the last result byte is read, `msr` returns to 0x80 and `irq` is low.
- R9: Seek (0x0F: unit, cylinder) and recalibrate (0x07: unit, cylinder 0) set `msr` bit n for drive n until `seek_done` names that drive. A `seek_done` for a drive that is not busy is ignored.
- R10: Sense interrupt status (0x08, no parameters) returns, for the lowest-numbered drive with a finished seek, ST0 = 0x20 | drive and its cylinder, and clears that drive's pending flag. With none pending it returns the single byte 0x80.
- R11: The interrupt request is raised by entry to the result phase from execution and by an accepted `seek_done`. `irq` follows it only while `irq_mask` is low. `drq` is high only during execution with `nondma` = 0 and `drq_mask` low.
- R12: A synchronous reset in any phase returns the sequencer to idle, clears busy and pending drives, and drops `irq` and `drq`.
- R13: During read execution `rd_valid` is high with `rd_data` = `exec_rdata`. During write or scan execution `wr_ready` is high. Each byte moved in execution pulses `xfer_ack` in its handshake cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_valid | input | 1 | Host offers a data byte |
| wr_data | input | 8 | Host data byte |
| wr_ready | output | 1 | Sequencer takes the offered byte |
| rd_valid | output | 1 | A byte is ready for the host |
| rd_ready | input | 1 | Host takes the byte |
| rd_data | output | 8 | Byte for the host |
| msr | output | 8 | Main status: phase flags and drive-busy bits |
| exec_start | output | 1 | One-cycle start for the execution stub or seek engine |
| exec_cmd | output | 8 | Full command byte, including option flags |
| exec_unit | output | 8 | Unit byte (head in bit 2, drive in bits 1:0) |
| exec_done | input | 1 | Stub finished execution |
| exec_status | input | 24 | Stub completion word |
| exec_rdata | input | 8 | Read-execution data byte from the stub |
| xfer_ack | output | 1 | A byte moved during execution |
| tc | input | 1 | Terminal count, ends a transfer |
| seek_done | input | 1 | Seek engine finished a drive |
| seek_drive | input | 2 | Drive that finished |
| irq_mask | input | 1 | Forces irq low |
| drq_mask | input | 1 | Forces drq low |
| irq | output | 1 | Interrupt request |
| drq | output | 1 | DMA request |
| step_rate | output | 4 | Step rate from Specify |
| nondma | output | 1 | Non-DMA mode from Specify |

## Verification
The main function is driven with distinct command byte streams: a two-parameter configuration command, an unknown code, full eight-parameter read, write and scan commands, seeks, and interrupt-status polls. The read/write/scan cases tell the three execution flag encodings apart. Ending one transfer by terminal count and another by stub completion shows that both end events latch the status word. A completion word whose low three bits differ from the unit selection shows that the drive/head substitution into the first result byte is taken from the unit byte and not from the status word. Seeks on two drives, finished in reverse order, followed by a stray completion on an idle drive, show the busy bits, the lowest-drive priority of the poll and the pending-flag clearing.

// File: rtl/fdc_seq_pkg.sv
package fdc_seq_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_CMD, PH_EXEC, PH_RES} phase_e;
  typedef enum logic [2:0] {
    K_INVALID, K_SPECIFY, K_SENSE, K_SEEK, K_RECAL, K_READ, K_WRITE, K_SCAN
  } kind_e;
  localparam logic [7:0] ST0_INVALID  = 8'h80;
  localparam logic [7:0] ST0_SEEK_END = 8'h20;
endpackage

// File: rtl/fdc_cmd_decode.sv
module fdc_cmd_decode
  import fdc_seq_pkg::*;
#(
  parameter int CNT_W   = 4,
  parameter int XFER_NP = 8
) (
  input  logic [7:0]       cmd,
  output kind_e            kind,
  output logic [CNT_W-1:0] nparams
);
  // R3: only the low five bits select the command
  always_comb begin
    kind    = K_INVALID;
    nparams = '0;
    case (cmd[4:0])
      5'h03:               begin kind = K_SPECIFY; nparams = CNT_W'(2); end
      5'h08:               begin kind = K_SENSE;   nparams = '0;        end
      5'h07:               begin kind = K_RECAL;   nparams = CNT_W'(1); end
      5'h0F:               begin kind = K_SEEK;    nparams = CNT_W'(2); end
      5'h06, 5'h0C:        begin kind = K_READ;    nparams = CNT_W'(XFER_NP); end
      5'h05, 5'h09:        begin kind = K_WRITE;   nparams = CNT_W'(XFER_NP); end
      5'h11, 5'h19, 5'h1D: begin kind = K_SCAN;    nparams = CNT_W'(XFER_NP); end
      default:             begin kind = K_INVALID; nparams = '0;        end
    endcase
  end
endmodule

// File: rtl/fdc_drive_track.sv
module fdc_drive_track #(
  parameter int NUM_DRIVES = 4,
  parameter int DRV_W      = 2
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start_vld,
  input  logic [DRV_W-1:0]      start_drv,
  input  logic [7:0]            start_cyl,
  input  logic                  done_vld,
  input  logic [DRV_W-1:0]      done_drv,
  input  logic                  clr_vld,
  input  logic [DRV_W-1:0]      clr_drv,
  output logic [NUM_DRIVES-1:0] busy,
  output logic                  done_acc,
  output logic                  pend_any,
  output logic [DRV_W-1:0]      pend_drv,
  output logic [7:0]            pend_cyl
);
  logic [NUM_DRIVES-1:0] pend;
  logic [NUM_DRIVES-1:0] done_hit;
  logic [7:0]            cyl_arr [NUM_DRIVES];

  for (genvar d = 0; d < NUM_DRIVES; d++) begin : g_drv
    logic       busy_r, pend_r;
    logic [7:0] cyl_r;
    logic       hit_start, hit_clr;
    assign hit_start   = start_vld && (start_drv == DRV_W'(d));
    assign hit_clr     = clr_vld && (clr_drv == DRV_W'(d));
    // R9: completion counts only for a drive that is positioning
    assign done_hit[d] = done_vld && (done_drv == DRV_W'(d)) && busy_r;
    always_ff @(posedge clk) begin
      if (rst) begin
        busy_r <= 1'b0;
        pend_r <= 1'b0;
        cyl_r  <= '0;
      end else begin
        busy_r <= hit_start | (busy_r & ~done_hit[d]);
        pend_r <= done_hit[d] | (pend_r & ~hit_clr);
        if (hit_start) cyl_r <= start_cyl;
      end
    end
    assign busy[d]    = busy_r;
    assign pend[d]    = pend_r;
    assign cyl_arr[d] = cyl_r;
  end

  assign done_acc = |done_hit;
  assign pend_any = |pend;

  // R10: lowest numbered pending drive wins
  always_comb begin
    pend_drv = '0;
    pend_cyl = '0;
    for (int d = NUM_DRIVES - 1; d >= 0; d--) begin
      if (pend[d]) begin
        pend_drv = DRV_W'(d);
        pend_cyl = cyl_arr[d];
      end
    end
  end
endmodule

// File: rtl/fdc_result_buf.sv
module fdc_result_buf #(
  parameter int DEPTH = 7,
  parameter int CNT_W = 3
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  load,
  input  logic [CNT_W-1:0]      load_len,
  input  logic [DEPTH-1:0][7:0] load_data,
  input  logic                  take,
  output logic [7:0]            byte_o,
  output logic                  last_o
);
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  logic [DEPTH-1:0][7:0] mem_q;
  logic [CNT_W-1:0]      len_q;
  logic [IDX_W-1:0]      idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mem_q <= '0;
      len_q <= '0;
      idx_q <= '0;
    end else if (load) begin
      mem_q <= load_data;
      len_q <= load_len;
      idx_q <= '0;
    end else if (take) begin
      idx_q <= idx_q + IDX_W'(1);
    end
  end

  assign byte_o = mem_q[idx_q];
  assign last_o = (CNT_W'(idx_q) == len_q - CNT_W'(1));
endmodule

// File: rtl/fdc_host_seq.sv
module fdc_host_seq
  import fdc_seq_pkg::*;
#(
  parameter int NUM_DRIVES = 4,
  parameter int MAX_PARAMS = 8,
  parameter int RES_BYTES  = 7
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wr_valid,
  input  logic [7:0]  wr_data,
  output logic        wr_ready,
  output logic        rd_valid,
  input  logic        rd_ready,
  output logic [7:0]  rd_data,
  output logic [7:0]  msr,
  output logic        exec_start,
  output logic [7:0]  exec_cmd,
  output logic [7:0]  exec_unit,
  input  logic        exec_done,
  input  logic [23:0] exec_status,
  input  logic [7:0]  exec_rdata,
  output logic        xfer_ack,
  input  logic        tc,
  input  logic        seek_done,
  input  logic [1:0]  seek_drive,
  input  logic        irq_mask,
  input  logic        drq_mask,
  output logic        irq,
  output logic        drq,
  output logic [3:0]  step_rate,
  output logic        nondma
);
  localparam int DRV_W  = (NUM_DRIVES > 1) ? $clog2(NUM_DRIVES) : 1;
  localparam int PCNT_W = $clog2(MAX_PARAMS + 1);
  localparam int PIDX_W = (MAX_PARAMS > 1) ? $clog2(MAX_PARAMS) : 1;
  localparam int RCNT_W = $clog2(RES_BYTES + 1);

  phase_e              phase_q;
  kind_e               kind_q, dec_kind;
  logic [7:0]          cmd_q;
  logic [PCNT_W-1:0]   pcnt_q, need_q, dec_np;
  logic [7:0]          par_q [MAX_PARAMS];
  logic [3:0]          step_q;
  logic                nondma_q, irq_req_q, start_q;
  logic [3:0]          flags;   // {RQM, DIO, NDM, CB}
  logic                wr_acc, rd_acc, last_par, exec_end;
  logic                seek_start, sense_now, res_load, res_last;
  logic [RCNT_W-1:0]   res_len;
  logic [RES_BYTES-1:0][7:0] res_bytes;
  logic [7:0]          res_byte;
  logic [DRV_W-1:0]    start_drv, pend_drv;
  logic [7:0]          start_cyl, pend_cyl;
  logic [NUM_DRIVES-1:0] busy;
  logic                pend_any, done_acc;

  fdc_cmd_decode #(.CNT_W(PCNT_W), .XFER_NP(MAX_PARAMS)) i_dec (
    .cmd(wr_data), .kind(dec_kind), .nparams(dec_np));

  // R2 R3 R6: phase flag encodings
  always_comb begin
    case (phase_q)
      PH_CMD:  flags = 4'b1001;
      PH_EXEC: flags = (kind_q == K_READ) ? 4'b1111 : 4'b1011;
      PH_RES:  flags = 4'b1101;
      default: flags = 4'b1000;
    endcase
  end

  assign msr      = {flags, 4'(busy)};
  assign wr_ready = flags[3] & ~flags[2];
  assign rd_valid = flags[3] & flags[2];
  assign wr_acc   = wr_valid & wr_ready;
  assign rd_acc   = rd_valid & rd_ready;
  assign rd_data  = (phase_q == PH_RES) ? res_byte : exec_rdata;
  assign xfer_ack = (phase_q == PH_EXEC) & (wr_acc | rd_acc);   // R13

  assign last_par   = wr_acc && (phase_q == PH_CMD) && (pcnt_q == need_q - PCNT_W'(1));
  assign seek_start = last_par && ((kind_q == K_SEEK) || (kind_q == K_RECAL));
  assign start_drv  = (kind_q == K_RECAL) ? wr_data[DRV_W-1:0] : par_q[0][DRV_W-1:0];
  assign start_cyl  = (kind_q == K_RECAL) ? 8'h00 : wr_data;
  assign sense_now  = wr_acc && (phase_q == PH_IDLE) && (dec_kind == K_SENSE);
  assign exec_end   = (phase_q == PH_EXEC) && (tc || exec_done);   // R7

  fdc_drive_track #(.NUM_DRIVES(NUM_DRIVES), .DRV_W(DRV_W)) i_drv (
    .clk(clk), .rst(rst),
    .start_vld(seek_start), .start_drv(start_drv), .start_cyl(start_cyl),
    .done_vld(seek_done), .done_drv(seek_drive[DRV_W-1:0]),
    .clr_vld(sense_now & pend_any), .clr_drv(pend_drv),
    .busy(busy), .done_acc(done_acc), .pend_any(pend_any),
    .pend_drv(pend_drv), .pend_cyl(pend_cyl));

  // R5 R7 R10: result byte assembly
  always_comb begin
    res_load  = 1'b0;
    res_len   = '0;
    res_bytes = '0;
    if (wr_acc && (phase_q == PH_IDLE) && (dec_kind == K_INVALID)) begin
      res_load     = 1'b1;
      res_len      = RCNT_W'(1);
      res_bytes[0] = ST0_INVALID;
    end else if (sense_now) begin
      res_load = 1'b1;
      if (pend_any) begin
        res_len      = RCNT_W'(2);
        res_bytes[0] = ST0_SEEK_END | 8'(pend_drv);
        res_bytes[1] = pend_cyl;
      end else begin
        res_len      = RCNT_W'(1);
        res_bytes[0] = ST0_INVALID;
      end
    end else if (exec_end) begin
      res_load     = 1'b1;
      res_len      = RCNT_W'(7);
      res_bytes[0] = {exec_status[7:3], par_q[0][2:0]};
      res_bytes[1] = exec_status[15:8];
      res_bytes[2] = exec_status[23:16];
      for (int i = 0; i < 4; i++) res_bytes[3+i] = par_q[1+i];
    end
  end

  fdc_result_buf #(.DEPTH(RES_BYTES), .CNT_W(RCNT_W)) i_res (
    .clk(clk), .rst(rst), .load(res_load), .load_len(res_len),
    .load_data(res_bytes), .take(rd_acc && (phase_q == PH_RES)),
    .byte_o(res_byte), .last_o(res_last));

  // R1 R12: synchronous reset to idle
  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q   <= PH_IDLE;
      kind_q    <= K_INVALID;
      cmd_q     <= '0;
      pcnt_q    <= '0;
      need_q    <= '0;
      step_q    <= '0;
      nondma_q  <= 1'b0;
      irq_req_q <= 1'b0;
      start_q   <= 1'b0;
      for (int i = 0; i < MAX_PARAMS; i++) par_q[i] <= '0;
    end else begin
      start_q   <= 1'b0;
      // R8 R11: raise on completion events, drop after the last result byte
      irq_req_q <= (irq_req_q & ~(rd_acc && (phase_q == PH_RES) && res_last))
                   | exec_end | done_acc;
      case (phase_q)
        PH_IDLE: if (wr_acc) begin
          cmd_q  <= wr_data;
          kind_q <= dec_kind;
          need_q <= dec_np;
          pcnt_q <= '0;
          phase_q <= ((dec_kind == K_INVALID) || (dec_kind == K_SENSE)) ? PH_RES : PH_CMD;
        end
        PH_CMD: if (wr_acc) begin
          par_q[pcnt_q[PIDX_W-1:0]] <= wr_data;
          pcnt_q <= pcnt_q + PCNT_W'(1);
          if (last_par) begin
            case (kind_q)
              K_SPECIFY: begin       // R4
                step_q   <= par_q[0][7:4];
                nondma_q <= wr_data[0];
                phase_q  <= PH_IDLE;
              end
              K_SEEK, K_RECAL: begin // R9
                start_q <= 1'b1;
                phase_q <= PH_IDLE;
              end
              default: begin         // R6
                start_q <= 1'b1;
                phase_q <= PH_EXEC;
              end
            endcase
          end
        end
        PH_EXEC: if (exec_end) phase_q <= PH_RES;
        default: if (rd_acc && res_last) phase_q <= PH_IDLE;
      endcase
    end
  end

  assign exec_start = start_q;
  assign exec_cmd   = cmd_q;
  assign exec_unit  = par_q[0];
  assign step_rate  = step_q;
  assign nondma     = nondma_q;
  assign irq        = irq_req_q & ~irq_mask;
  assign drq        = (phase_q == PH_EXEC) & ~nondma_q & ~drq_mask;
endmodule

// File: rtl/fdc_host_seq_chk.sv
module fdc_host_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic [7:0] msr,
  input logic       irq,
  input logic       drq,
  input logic       irq_mask,
  input logic       drq_mask,
  input logic       tc,
  input logic       exec_start,
  input logic       rd_valid,
  input logic       wr_ready,
  input logic       seek_done
);
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    irq_mask |-> !irq);  // R11
  AST_DRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    drq_mask |-> !drq);  // R11
  AST_DRQ_IN_EXEC: assert property (@(posedge clk) disable iff (rst)
    drq |-> (msr[7] && msr[5] && msr[4]));  // R11
  AST_START_PULSE: assert property (@(posedge clk) disable iff (rst)
    exec_start |=> !exec_start);  // R6
  AST_TC_ENDS_EXEC: assert property (@(posedge clk) disable iff (rst)
    (tc && msr[5]) |=> (msr[7:4] == 4'hD));  // R7
  AST_RESULT_EXIT_IRQ: assert property (@(posedge clk) disable iff (rst)
    ($fell(msr[4]) && $past(msr[6]) && !$past(seek_done)) |-> !irq);  // R8
  AST_DIR_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(rd_valid && wr_ready));  // R2
endmodule

bind fdc_host_seq fdc_host_seq_chk i_chk (.*);

// File: tb/test_fdc_host_seq.sv
module test_fdc_host_seq;
  logic        clk = 0, rst = 1;
  logic        wr_valid = 0, rd_ready = 0, exec_done = 0, tc = 0, seek_done = 0;
  logic        irq_mask = 0, drq_mask = 0;
  logic [7:0]  wr_data = 0, exec_rdata = 0;
  logic [23:0] exec_status = 0;
  logic [1:0]  seek_drive = 0;
  logic        wr_ready, rd_valid, exec_start, xfer_ack, irq, drq, nondma;
  logic [7:0]  rd_data, msr, exec_cmd, exec_unit;
  logic [3:0]  step_rate;
  int          n_chk = 0, n_fail = 0;
  bit          done = 0;

  fdc_host_seq i_fdc_host_seq (.*);

  always #4 clk = ~clk;  // 125 MHz

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic host_wr(input logic [7:0] b);
    int tmo = 0;
    @(negedge clk);
    while (!wr_ready && tmo < 100) begin @(negedge clk); tmo++; end
    wr_valid = 1; wr_data = b;
    @(negedge clk);
    wr_valid = 0;
  endtask

  task automatic host_rd(output logic [7:0] b);
    int tmo = 0;
    @(negedge clk);
    while (!rd_valid && tmo < 100) begin @(negedge clk); tmo++; end
    b = rd_data; rd_ready = 1;
    @(negedge clk);
    rd_ready = 0;
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1;
    @(negedge clk); s = 0;
  endtask

  task automatic send_xfer(input logic [7:0] c, input logic [7:0] u, input logic [7:0] cy,
                           input logic [7:0] h, input logic [7:0] r, input logic [7:0] n);
    host_wr(c); host_wr(u); host_wr(cy); host_wr(h); host_wr(r); host_wr(n);
    host_wr(8'h09); host_wr(8'h1B); host_wr(8'hFF);
  endtask

  task automatic t_reset;
    chk("R1", "msr", msr, 8'h80);
    chk("R1", "irq", irq, 0);
    chk("R1", "drq", drq, 0);
    chk("R1", "rd_valid", rd_valid, 0);
    chk("R1", "wr_ready", wr_ready, 1);
  endtask

  task automatic t_specify;
    host_wr(8'h03);
    chk("R3", "msr cmd phase", msr, 8'h90);
    host_wr(8'hA5); host_wr(8'h01);
    chk("R4", "step_rate", step_rate, 4'hA);
    chk("R4", "nondma", nondma, 1);
    chk("R4", "msr", msr, 8'h80);
    chk("R4", "no result", rd_valid, 0);
    host_wr(8'h03); host_wr(8'h30); host_wr(8'h00);
    chk("R4", "step_rate 2", step_rate, 4'h3);
    chk("R4", "nondma 2", nondma, 0);
  endtask

  task automatic t_invalid;
    logic [7:0] b;
    host_wr(8'h1F);
    chk("R5", "msr result", msr, 8'hD0);
    chk("R2", "wr_ready in result", wr_ready, 0);
    @(negedge clk); wr_valid = 1; wr_data = 8'h03;
    @(negedge clk); wr_valid = 0;
    chk("R2", "ignored write msr", msr, 8'hD0);
    host_rd(b);
    chk("R5", "invalid byte", b, 8'h80);
    chk("R8", "msr idle", msr, 8'h80);
  endtask

  task automatic t_read_tc;
    logic [7:0] b;
    logic [7:0] exp [7] = '{8'h6D, 8'h40, 8'h10, 8'h12, 8'h01, 8'h03, 8'h02};
    send_xfer(8'hE6, 8'h05, 8'h12, 8'h01, 8'h03, 8'h02);
    chk("R6", "exec_start", exec_start, 1);
    chk("R3", "exec_cmd flags", exec_cmd, 8'hE6);
    chk("R6", "exec_unit", exec_unit, 8'h05);
    chk("R6", "msr read exec", msr, 8'hF0);
    @(negedge clk);
    chk("R6", "exec_start one cycle", exec_start, 0);
    chk("R11", "drq dma exec", drq, 1);
    drq_mask = 1; #1;
    chk("R11", "drq masked", drq, 0);
    drq_mask = 0;
    exec_rdata = 8'h5A;
    @(negedge clk); rd_ready = 1; #1;
    chk("R13", "exec rd_data", rd_data, 8'h5A);
    chk("R13", "xfer_ack read", xfer_ack, 1);
    @(negedge clk); rd_ready = 0;
    exec_status = 24'h104068;
    pulse(tc);
    chk("R7", "msr result", msr, 8'hD0);
    chk("R11", "irq", irq, 1);
    chk("R11", "drq after exec", drq, 0);
    irq_mask = 1; #1;
    chk("R11", "irq masked", irq, 0);
    irq_mask = 0;
    for (int i = 0; i < 7; i++) begin
      host_rd(b);
      chk("R7", $sformatf("result byte %0d", i), b, exp[i]);
    end
    chk("R8", "msr idle", msr, 8'h80);
    chk("R8", "irq cleared", irq, 0);
  endtask

  task automatic t_write_done;
    logic [7:0] b;
    send_xfer(8'h45, 8'h02, 8'h07, 8'h00, 8'h01, 8'h01);
    chk("R6", "msr write exec", msr, 8'hB0);
    @(negedge clk); wr_valid = 1; wr_data = 8'hC3; #1;
    chk("R13", "wr_ready exec", wr_ready, 1);
    chk("R13", "xfer_ack write", xfer_ack, 1);
    @(negedge clk); wr_valid = 0;
    exec_status = 24'h000007;
    pulse(exec_done);
    chk("R7", "msr after done", msr, 8'hD0);
    host_rd(b); chk("R7", "byte0 unit subst", b, 8'h02);
    host_rd(b); host_rd(b); host_rd(b);
    chk("R7", "byte3 C", b, 8'h07);
    for (int i = 0; i < 3; i++) host_rd(b);
    chk("R8", "msr idle", msr, 8'h80);
  endtask

  task automatic t_scan_nondma;
    logic [7:0] b;
    host_wr(8'h03); host_wr(8'h30); host_wr(8'h01);
    send_xfer(8'h11, 8'h00, 8'h01, 8'h00, 8'h01, 8'h01);
    chk("R6", "msr scan exec", msr, 8'hB0);
    chk("R11", "drq nondma", drq, 0);
    exec_status = 24'h0;
    pulse(tc);
    for (int i = 0; i < 7; i++) host_rd(b);
    chk("R8", "msr idle", msr, 8'h80);
    host_wr(8'h03); host_wr(8'h30); host_wr(8'h00);
  endtask

  task automatic t_seek_sense;
    logic [7:0] b;
    host_wr(8'h0F); host_wr(8'h02); host_wr(8'h28);
    chk("R9", "busy drive2", msr, 8'h84);
    seek_drive = 2'd3; pulse(seek_done);
    chk("R9", "stray done ignored", msr, 8'h84);
    chk("R9", "stray done no irq", irq, 0);
    host_wr(8'h07); host_wr(8'h01);
    chk("R9", "busy drives 1 2", msr, 8'h86);
    seek_drive = 2'd2; pulse(seek_done);
    chk("R9", "drive2 done", msr, 8'h82);
    chk("R11", "seek irq", irq, 1);
    seek_drive = 2'd1; pulse(seek_done);
    chk("R9", "drive1 done", msr, 8'h80);
    host_wr(8'h08);
    chk("R10", "sense msr", msr, 8'hD0);
    host_rd(b); chk("R10", "sense st0 drv1", b, 8'h21);
    host_rd(b); chk("R10", "sense cyl drv1", b, 8'h00);
    chk("R8", "irq after sense", irq, 0);
    host_wr(8'h08);
    host_rd(b); chk("R10", "sense st0 drv2", b, 8'h22);
    host_rd(b); chk("R10", "sense cyl drv2", b, 8'h28);
    host_wr(8'h08);
    host_rd(b); chk("R10", "sense none", b, 8'h80);
    chk("R10", "single byte", msr, 8'h80);
  endtask

  task automatic t_sync_reset;
    logic [7:0] b;
    host_wr(8'h0F); host_wr(8'h00); host_wr(8'h05);
    host_wr(8'h06); host_wr(8'h00);
    chk("R12", "pre-reset msr", msr, 8'h91);
    pulse(rst);
    chk("R12", "msr after reset", msr, 8'h80);
    chk("R12", "wr_ready", wr_ready, 1);
    chk("R12", "irq", irq, 0);
    seek_drive = 2'd0; pulse(seek_done);
    host_wr(8'h08);
    host_rd(b); chk("R12", "no pending after reset", b, 8'h80);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset;
    t_specify;
    t_invalid;
    t_read_tc;
    t_write_done;
    t_scan_nondma;
    t_seek_sense;
    t_sync_reset;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule